// File: doc/BRIEF.md
# Two-Target Priority Threshold Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and routes each one to one of two processor interrupt outputs: a fast interrupt line and a standard interrupt line. Every source carries a programmable 4-bit priority and a target select bit. Each target has its own priority threshold. A source reaches its target only while its priority is strictly above that target's threshold. Priority zero therefore never gets through.

Firmware can raise any request itself through a set of sticky software request bits. These are ORed with the hardware lines. For each target, the block reports which pending request currently wins and at what priority. A small synchronous write port with a combinational read port holds all configuration.

Register map (6-bit address, 16-bit data). Addresses 0x00 to NUM_SRC-1 are per-source configuration, with bits [3:0] holding the priority and bit 4 the target (0 = fast, 1 = standard). 0x10 holds the fast-target threshold in bits [3:0], and 0x11 the standard-target threshold. A write of ones to 0x12 sets software request bits, and reading 0x12 returns them. A write of ones to 0x13 clears software request bits. 0x14 and 0x15 read back the winner of the fast and standard target, with bit 8 = valid, bits [7:4] = priority and bits [3:0] = source index.

Top module: `irq_route_ctrl`

## Requirements
- R1: While and after reset (rst_ni low), fiq_o and irq_o are 0. All priorities, targets, thresholds and software bits read 0, and both winner words read 0. With that reset configuration no request line asserts an output.
- R2: A source whose configuration bit 4 is 0 can only drive fiq_o. A source whose bit 4 is 1 can only drive irq_o. Rewriting bit 4 moves the source to the other output.
- R3: A request counts for its target only when its priority is strictly greater than that target's threshold. A priority equal to the threshold is masked.
- R4: A request with priority 0 never asserts either output and never appears as a winner.
- R5: The winner word of a target (bit 8 valid, bits [7:4] priority, bits [3:0] index) names the highest-priority qualifying request. When priorities are equal, the lowest source index wins.
- R6: An output rises at the first clock edge after a qualifying request appears. It falls at the first clock edge after no qualifying request remains. The winner word updates at the same edges.
- R7: Writing ones to 0x12 sets the matching software request bits. They stay set with no hardware request and read back at 0x12.
- R8: Writing ones to 0x13 clears the matching software request bits. Other bits are left unchanged.
- R9: The effective request of a source is its hardware line OR its software bit. Removing either one alone keeps the request pending.
- R10: Each target uses only its own threshold. Changing the fast-target threshold has no effect on irq_o or on the standard winner word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Hardware request lines, level sensitive |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on address |
| fiq_o | output | 1 | Fast interrupt output (target 0) |
| irq_o | output | 1 | Standard interrupt output (target 1) |

## Verification
A corrupted priority, target or threshold register shows up as a wrong winner word or a wrong output level. This appears at the first clock edge after a request that involves that source is raised. A software request bit that is stuck or was lost changes an output within one edge, even with all hardware lines low. An error in the tie-break or the compare logic appears only under overlapping requests of equal priority, or with a priority equal to a threshold. The vector table therefore drives these patterns on purpose, and the bench reads both winner words after every edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PRIO_W  = 4;
  localparam int NUM_TGT = 2;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;

  typedef logic [PRIO_W-1:0] prio_t;

  localparam logic [ADDR_W-1:0] ADR_THR0   = 6'h10;
  localparam logic [ADDR_W-1:0] ADR_THR1   = 6'h11;
  localparam logic [ADDR_W-1:0] ADR_SW_SET = 6'h12;
  localparam logic [ADDR_W-1:0] ADR_SW_CLR = 6'h13;
  localparam logic [ADDR_W-1:0] ADR_WIN0   = 6'h14;
  localparam logic [ADDR_W-1:0] ADR_WIN1   = 6'h15;

  localparam int CFG_TGT_BIT = 4;
  localparam int WIN_VLD_BIT = 8;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
  output logic [NUM_SRC-1:0]               tgt_o,
  output logic [NUM_TGT-1:0][PRIO_W-1:0]   thr_o,
  output logic [NUM_SRC-1:0]               sw_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[i] <= '0;
        tgt_o[i]  <= 1'b0;
      end else if (we_i && addr_i == ADDR_W'(i)) begin
        prio_o[i] <= wdata_i[PRIO_W-1:0];
        tgt_o[i]  <= wdata_i[CFG_TGT_BIT];
      end
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  thr_o[t] <= '0;
      else if (we_i && addr_i == ADR_THR0 + ADDR_W'(t)) thr_o[t] <= wdata_i[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sw_o <= '0;
    else if (we_i && addr_i == ADR_SW_SET)   sw_o <= sw_o | wdata_i[NUM_SRC-1:0];
    else if (we_i && addr_i == ADR_SW_CLR)   sw_o <= sw_o & ~wdata_i[NUM_SRC-1:0];
  end

  // R8: cleared bits are gone one edge after the clear write
  a_r8_sw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_SW_CLR) |=> ((sw_o & $past(wdata_i[NUM_SRC-1:0])) == '0));

  // R7: set bits are present one edge after the set write
  a_r7_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_SW_SET) |=> ((sw_o & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));
endmodule

// File: rtl/irq_tgt_arb.sv
module irq_tgt_arb
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int TGT_ID  = 0,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC-1:0]             tgt_i,
  input  prio_t                          thr_i,
  output logic                           irq_o,
  output logic                           win_vld_o,
  output prio_t                          win_prio_o,
  output logic [IDX_W-1:0]               win_idx_o
);
  logic [NUM_SRC-1:0] elig;
  logic               best_vld;
  prio_t              best_prio;
  logic [IDX_W-1:0]   best_idx;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = req_i[i] && (tgt_i[i] == 1'(TGT_ID)) && (prio_i[i] > thr_i);
  end

  // ascending scan with strict compare keeps lowest index on ties
  always_comb begin
    best_vld  = 1'b0;
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!best_vld || prio_i[i] > best_prio)) begin
        best_vld  = 1'b1;
        best_prio = prio_i[i];
        best_idx  = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      win_vld_o  <= 1'b0;
      win_prio_o <= '0;
      win_idx_o  <= '0;
    end else begin
      irq_o      <= |elig;
      win_vld_o  <= best_vld;
      win_prio_o <= best_prio;
      win_idx_o  <= best_idx;
    end
  end

  a_r3_win_above_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (win_prio_o > $past(thr_i)));

  a_r4_win_prio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (win_prio_o != '0));

  a_r6_idle_when_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> !irq_o);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               reg_we_i,
  input  logic [5:0]         reg_addr_i,
  input  logic [15:0]        reg_wdata_i,
  output logic [15:0]        reg_rdata_o,
  output logic               fiq_o,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             tgt_q;
  logic [NUM_TGT-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC-1:0]             sw_q;
  logic [NUM_SRC-1:0]             req_eff;

  logic [NUM_TGT-1:0]             tgt_out;
  logic [NUM_TGT-1:0]             win_vld;
  logic [NUM_TGT-1:0][PRIO_W-1:0] win_prio;
  logic [NUM_TGT-1:0][IDX_W-1:0]  win_idx;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .prio_o  (prio_q),
    .tgt_o   (tgt_q),
    .thr_o   (thr_q),
    .sw_o    (sw_q)
  );

  assign req_eff = irq_src_i | sw_q;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    irq_tgt_arb #(.NUM_SRC(NUM_SRC), .TGT_ID(t)) i_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_eff),
      .prio_i     (prio_q),
      .tgt_i      (tgt_q),
      .thr_i      (thr_q[t]),
      .irq_o      (tgt_out[t]),
      .win_vld_o  (win_vld[t]),
      .win_prio_o (win_prio[t]),
      .win_idx_o  (win_idx[t])
    );
  end

  assign fiq_o = tgt_out[0];
  assign irq_o = tgt_out[1];

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr_i == ADDR_W'(i)) begin
        reg_rdata_o[PRIO_W-1:0]  = prio_q[i];
        reg_rdata_o[CFG_TGT_BIT] = tgt_q[i];
      end
    end
    case (reg_addr_i)
      ADR_THR0:   reg_rdata_o[PRIO_W-1:0] = thr_q[0];
      ADR_THR1:   reg_rdata_o[PRIO_W-1:0] = thr_q[1];
      ADR_SW_SET: reg_rdata_o[NUM_SRC-1:0] = sw_q;
      ADR_WIN0:   reg_rdata_o[WIN_VLD_BIT:0] = {win_vld[0], win_prio[0], 4'(win_idx[0])};
      ADR_WIN1:   reg_rdata_o[WIN_VLD_BIT:0] = {win_vld[1], win_prio[1], 4'(win_idx[1])};
      default: ;
    endcase
  end

  // R2: a source belongs to one target, so the two winners never coincide
  a_r2_winners_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld[0] && win_vld[1]) |-> (win_idx[0] != win_idx[1]));

  a_r5_out_matches_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o == win_vld[0]) && (irq_o == win_vld[1]));
endmodule

// File: tb/test_irq_route_ctrl.sv
`timescale 1ns/1ps
module test_irq_route_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic         fiq, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_ctrl #(.NUM_SRC(N)) i_irq_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  // {hw[27:20], fiq[19], irq[18], win0[17:9], win1[8:0]}
  // cfg: s0 p3 t0, s1 p7 t0, s2 p7 t0, s3 p0 t0, s4 p5 t1, s5 p15 t1, s6 p1 t1, s7 p2 t1; thr0=2 thr1=1
  localparam logic [27:0] VEC [10] = '{
    {8'h00, 1'b0, 1'b0, 9'h000, 9'h000},
    {8'h01, 1'b1, 1'b0, 9'h130, 9'h000},  // R5 single
    {8'h06, 1'b1, 1'b0, 9'h171, 9'h000},  // R5 tie -> lowest index
    {8'h05, 1'b1, 1'b0, 9'h172, 9'h000},  // R5 higher prio wins
    {8'h08, 1'b0, 1'b0, 9'h000, 9'h000},  // R4 prio 0
    {8'h40, 1'b0, 1'b0, 9'h000, 9'h000},  // R3 prio == thr
    {8'h80, 1'b0, 1'b1, 9'h000, 9'h127},  // R3 prio > thr
    {8'h30, 1'b0, 1'b1, 9'h000, 9'h1F5},
    {8'hFF, 1'b1, 1'b1, 9'h171, 9'h1F5},
    {8'h4C, 1'b1, 1'b0, 9'h172, 9'h000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    // R1 during reset
    src = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 fiq in reset", 16'(fiq), 16'h0);
    chk("R1 irq in reset", 16'(irq), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    step(); step();
    chk("R1 masked fiq", 16'(fiq), 16'h0);
    chk("R1 masked irq", 16'(irq), 16'h0);
    rd(6'h00, d); chk("R1 cfg0", d, 16'h0);
    rd(6'h10, d); chk("R1 thr0", d, 16'h0);
    rd(6'h12, d); chk("R1 sw", d, 16'h0);
    rd(6'h14, d); chk("R1 win0", d, 16'h0);
    rd(6'h15, d); chk("R1 win1", d, 16'h0);
    src = '0;

    wr(6'h00, 16'h03); wr(6'h01, 16'h07); wr(6'h02, 16'h07); wr(6'h03, 16'h00);
    wr(6'h04, 16'h15); wr(6'h05, 16'h1F); wr(6'h06, 16'h11); wr(6'h07, 16'h12);
    wr(6'h10, 16'h2);  wr(6'h11, 16'h1);
    rd(6'h05, d); chk("R2 cfg readback", d, 16'h1F);

    foreach (VEC[k]) begin
      @(negedge clk);
      src = VEC[k][27:20];
      step();
      chk($sformatf("R5 vec%0d fiq", k), 16'(fiq), 16'(VEC[k][19]));
      chk($sformatf("R5 vec%0d irq", k), 16'(irq), 16'(VEC[k][18]));
      rd(6'h14, d); chk($sformatf("R5 vec%0d win0", k), d, 16'(VEC[k][17:9]));
      rd(6'h15, d); chk($sformatf("R5 vec%0d win1", k), d, 16'(VEC[k][8:0]));
    end

    // R6 timing
    @(negedge clk); src = '0;
    step();
    @(negedge clk); src = 8'h02;
    #1; chk("R6 not before edge", 16'(fiq), 16'h0);
    step(); chk("R6 rise after one edge", 16'(fiq), 16'h1);
    @(negedge clk); src = '0;
    #1; chk("R6 held before edge", 16'(fiq), 16'h1);
    step(); chk("R6 fall after one edge", 16'(fiq), 16'h0);
    rd(6'h14, d); chk("R6 win0 cleared", d, 16'h0);

    // R7 software set
    wr(6'h12, 16'h20);
    rd(6'h12, d); chk("R7 sw readback", d, 16'h20);
    step(); chk("R7 sw raises irq", 16'(irq), 16'h1);
    rd(6'h15, d); chk("R7 sw winner", d, 16'h1F5);

    // R9 OR of hw and sw
    @(negedge clk); src = 8'h20;
    wr(6'h13, 16'h20);
    rd(6'h12, d); chk("R8 sw cleared", d, 16'h0);
    step(); chk("R9 hw keeps request", 16'(irq), 16'h1);
    @(negedge clk); src = '0;
    step(); chk("R9 released", 16'(irq), 16'h0);

    // R8 selective clear
    wr(6'h12, 16'h06);
    wr(6'h13, 16'h02);
    rd(6'h12, d); chk("R8 other bits kept", d, 16'h04);
    step(); rd(6'h14, d); chk("R8 remaining sw winner", d, 16'h172);
    wr(6'h13, 16'hFF);
    step(); chk("R8 all cleared fiq", 16'(fiq), 16'h0);

    // R10 per-target threshold
    wr(6'h10, 16'h7);
    @(negedge clk); src = 8'hFF;
    step();
    chk("R10 fiq masked by thr0", 16'(fiq), 16'h0);
    chk("R10 irq unaffected", 16'(irq), 16'h1);
    rd(6'h14, d); chk("R10 win0 empty", d, 16'h0);
    rd(6'h15, d); chk("R10 win1 unchanged", d, 16'h1F5);

    // R2 retarget source 0
    @(negedge clk); src = '0;
    wr(6'h10, 16'h2);
    wr(6'h00, 16'h13);
    @(negedge clk); src = 8'h01;
    step();
    chk("R2 retarget fiq", 16'(fiq), 16'h0);
    chk("R2 retarget irq", 16'(irq), 16'h1);
    rd(6'h15, d); chk("R2 retarget win1", d, 16'h130);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule